// File: doc/BRIEF.md
# Instruction Fetch Bus Snooper

This block sits passively beside a 68000-style asynchronous bus and turns every instruction fetch it sees into one trace record: the fetch address and the 16-bit word that was read. It only listens. No pin of the monitored bus is ever driven. Records leave the block as a registered address and data pair with a one-clock valid pulse, which a trace buffer downstream can store.

The bus strobes run with no relation to the sampling clock, so they are first brought into the clock domain through a flip-flop chain. Edges are then found on the synchronised strobes. The address, function code and direction are taken when the address strobe is seen falling. The data word is taken later, when a late-cycle data-valid qualifier is seen asserting. The transfer acknowledge is deliberately not used to capture the data, because it arrives several bus states before the data lines settle. If the address strobe closes the cycle before the qualifier has come, the cycle is dropped and a saturating error counter goes up by one.

Top module: `ifetch_snoop`

## Requirements
- R1: While reset is held and on the first cycle after it, `rec_valid` is 0 and `err_count` is 0.
- R2: A read cycle with `bus_fc` equal to 3'b010 (user program) or 3'b110 (supervisor program) produces a record. Any other function code, such as 3'b001, 3'b101, 3'b111 or 3'b000, produces no record and does not change `err_count`.
- R3: A cycle with `bus_rw` = 0 (write) produces no record, even when the function code marks a program fetch.
- R4: `rec_addr` holds the value `bus_addr` had when the falling edge of `bus_as_n` was taken. It is not affected by any later change of `bus_addr` within the cycle.
- R5: `rec_data` holds the value `bus_data` had when the falling edge of `bus_dv_n` was taken. It is not the value present at the address strobe edge.
- R6: `rec_valid` rises on the third rising clock edge after `bus_dv_n` falls, and it stays high for exactly one clock.
- R7: Back-to-back fetch cycles each produce their own record with their own address and data. This covers extension words as well as opcode words.
- R8: If `bus_as_n` rises in a fetch cycle before `bus_dv_n` has fallen, no record is produced and `err_count` increases by one.
- R9: `err_count` saturates at its all-ones value and stays there on further aborted cycles.
- R10: Only the first falling edge of `bus_dv_n` within one address-strobe cycle produces a record. Later qualifier edges before `bus_as_n` rises are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 24 | Monitored address bus |
| bus_data | input | 16 | Monitored data bus |
| bus_fc | input | 3 | Monitored function-code lines |
| bus_as_n | input | 1 | Address strobe, active low, asynchronous |
| bus_rw | input | 1 | Direction: 1 means read, 0 means write |
| bus_dv_n | input | 1 | Late-cycle data-valid qualifier, active low, asynchronous |
| rec_valid | output | 1 | One-clock pulse marking a new record |
| rec_addr | output | 24 | Fetch address of the record |
| rec_data | output | 16 | Fetched word of the record |
| err_count | output | ERR_W | Saturating count of cycles closed before data was valid |

## Verification
The embedded assertions check several properties on every clock. The valid pulse never lasts two cycles. A write or a non-program function code never arms the capture. An early strobe release never yields a record. A second qualifier edge within one cycle is never turned into a record. A saturated counter stays put.

Some properties can only be shown by the bench scenarios. These are the values carried in each record: the address frozen at the strobe edge while the bus lines change afterwards, and the data taken at the qualifier rather than at the strobe. The bench also shows the exact three-edge latency, the run of consecutive fetches, and the counter climbing to saturation.

// File: rtl/ifs_pkg.sv
// Package ifs_pkg
// Shared types and helpers for the instruction fetch snooper.
// Assumes function codes follow the usual 68000 encoding, in which
// bits [1:0] = 2'b10 mark program space for both user and supervisor.
package ifs_pkg;

    // Function-code values that denote an instruction fetch.
    localparam logic [2:0] FC_USER_PROG = 3'b010;
    localparam logic [2:0] FC_SUPV_PROG = 3'b110;

    // Index of each strobe inside the synchroniser vector.
    localparam int STB_AS = 0;
    localparam int STB_DV = 1;
    localparam int STB_N  = 2;

    // Capture sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for an address strobe edge
        ST_ARMED = 2'd1,   // fetch address held, waiting for data qualifier
        ST_DONE  = 2'd2    // record emitted, waiting for strobe release
    } ifs_state_t;

    // True when the function code marks a program (instruction) access.
    function automatic logic fc_is_fetch(input logic [2:0] fc);
        return (fc == FC_USER_PROG) || (fc == FC_SUPV_PROG);
    endfunction

endpackage

// File: rtl/ifs_sync.sv
// Module ifs_sync
// Multi-stage synchroniser for a vector of asynchronous strobes.
// Assumes each bit is an independent level signal. On reset every stage
// loads RST_VAL, the idle level of the strobes, so no edge is seen
// when reset is released.
module ifs_sync #(
    parameter int   WIDTH   = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam int TOTAL = WIDTH * STAGES;

    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the raw strobes through the flip-flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {TOTAL{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/ifs_edge.sv
// Module ifs_edge
// Per-bit falling and rising edge detector on synchronised levels.
// Assumes the inputs are already in the clk domain. The history register
// resets to the idle-high level, so no edge is seen right after reset.
module ifs_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] fall,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] prev;

    // Remember last cycle's level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= lvl;
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        // Compare current and previous level of one strobe.
        always_comb begin
            fall[g] = prev[g] & ~lvl[g];
            rise[g] = ~prev[g] & lvl[g];
        end
    end

endmodule

// File: rtl/ifs_err_ctr.sv
// Module ifs_err_ctr
// Saturating counter of aborted fetch cycles.
// Assumes inc is a single-cycle pulse. The count stops at all-ones.
module ifs_err_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] CNT_MAX = '1;

    // Count each abort pulse until the maximum is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (inc && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
    end

    // R9: once saturated the counter never moves.
    a_r9_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX) |=> (cnt == CNT_MAX));

    // R8: an abort pulse below saturation always moves the count.
    a_r8_abort_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt != CNT_MAX) |=> (cnt != $past(cnt)));

endmodule

// File: rtl/ifs_capture.sv
// Module ifs_capture
// Two-point capture sequencer. It takes the address, function code and
// direction on the address-strobe fall. It takes the data word on the
// data-valid qualifier fall, and then emits one registered record.
// Assumes the address, function-code and direction lines are stable
// from before the strobe falls until it rises. Assumes the data lines
// are stable from before the qualifier falls until the strobe rises.
module ifs_capture
    import ifs_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_fall,
    input  logic              as_rise,
    input  logic              dv_fall,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [2:0]        bus_fc,
    input  logic              bus_rw,
    output logic              rec_valid,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [DATA_W-1:0] rec_data,
    output logic              abort
);

    ifs_state_t        st, st_nxt;
    logic [ADDR_W-1:0] addr_q;
    logic              arm, fire, drop;

    // Decode the transitions of the capture sequence.
    always_comb begin
        arm    = (st == ST_IDLE) && as_fall && bus_rw && fc_is_fetch(bus_fc);
        fire   = (st == ST_ARMED) && dv_fall;
        drop   = (st == ST_ARMED) && !dv_fall && as_rise;
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (arm)          st_nxt = ST_ARMED;
            ST_ARMED: if (fire)         st_nxt = ST_DONE;
                      else if (drop)    st_nxt = ST_IDLE;
            ST_DONE:  if (as_rise)      st_nxt = ST_IDLE;
            default:                    st_nxt = ST_IDLE;
        endcase
    end

    // Advance the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Hold the fetch address taken at the strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n)   addr_q <= '0;
        else if (arm) addr_q <= bus_addr;
    end

    // Build the outgoing record when the data qualifier arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid <= 1'b0;
            rec_addr  <= '0;
            rec_data  <= '0;
        end else begin
            rec_valid <= fire;
            if (fire) begin
                rec_addr <= addr_q;
                rec_data <= bus_data;
            end
        end
    end

    // Raise the abort pulse when the strobe closes before data is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) abort <= 1'b0;
        else        abort <= drop;
    end

    // R6: the record pulse lasts a single clock.
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> !rec_valid);

    // R3: a write cycle never leaves the idle state.
    a_r3_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && as_fall && !bus_rw) |=> (st == ST_IDLE));

    // R2: a non-program function code never arms the capture.
    a_r2_fc_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && as_fall && !fc_is_fetch(bus_fc)) |=> (st == ST_IDLE));

    // R8: an early strobe release yields no record, and the abort goes out.
    a_r8_abort_no_record: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED && as_rise && !dv_fall) |=> (!rec_valid && abort));

    // R10: a second qualifier edge in the same cycle is ignored.
    a_r10_one_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && dv_fall) |=> !rec_valid);

endmodule

// File: rtl/ifetch_snoop.sv
// Module ifetch_snoop
// Top of the instruction fetch bus snooper. It synchronises the two
// asynchronous strobes, finds their edges, runs the two-point capture
// and counts aborted fetch cycles. It never drives the monitored bus.
// Assumes a sampling clock several times faster than a bus state, so that
// each strobe level lasts at least three clocks.
module ifetch_snoop
    import ifs_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 16,
    parameter int ERR_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [2:0]        bus_fc,
    input  logic              bus_as_n,
    input  logic              bus_rw,
    input  logic              bus_dv_n,
    output logic              rec_valid,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [DATA_W-1:0] rec_data,
    output logic [ERR_W-1:0]  err_count
);

    logic [STB_N-1:0] stb_raw, stb_sync, stb_fall, stb_rise;
    logic             abort;

    // Gather the raw strobes into one vector.
    always_comb begin
        stb_raw         = '1;
        stb_raw[STB_AS] = bus_as_n;
        stb_raw[STB_DV] = bus_dv_n;
    end

    ifs_sync #(
        .WIDTH   (STB_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (stb_raw),
        .q     (stb_sync)
    );

    ifs_edge #(
        .WIDTH (STB_N)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (stb_sync),
        .fall  (stb_fall),
        .rise  (stb_rise)
    );

    ifs_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_fall   (stb_fall[STB_AS]),
        .as_rise   (stb_rise[STB_AS]),
        .dv_fall   (stb_fall[STB_DV]),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .bus_fc    (bus_fc),
        .bus_rw    (bus_rw),
        .rec_valid (rec_valid),
        .rec_addr  (rec_addr),
        .rec_data  (rec_data),
        .abort     (abort)
    );

    ifs_err_ctr #(
        .W (ERR_W)
    ) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (abort),
        .cnt   (err_count)
    );

    // R1: no record can come out in the first cycle after reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!rec_valid && err_count == '0));

endmodule

// File: tb/ifetch_snoop_bench.sv
// Directed bench for ifetch_snoop. Each scenario task checks its own results.
module ifetch_snoop_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ERR_W_TB   = 3;
    localparam int ERR_MAX    = (1 << ERR_W_TB) - 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [23:0]         bus_addr = '0;
    logic [15:0]         bus_data = '0;
    logic [2:0]          bus_fc = '0;
    logic                bus_as_n = 1'b1;
    logic                bus_rw = 1'b1;
    logic                bus_dv_n = 1'b1;
    logic                rec_valid;
    logic [23:0]         rec_addr;
    logic [15:0]         rec_data;
    logic [ERR_W_TB-1:0] err_count;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    int exp_err = 0;
    bit finished = 1'b0;

    ifetch_snoop #(.ERR_W(ERR_W_TB)) u_ifetch_snoop (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_fc(bus_fc), .bus_as_n(bus_as_n), .bus_rw(bus_rw), .bus_dv_n(bus_dv_n),
        .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_data(rec_data),
        .err_count(err_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count record pulses, sampled away from the active edge.
    always @(negedge clk) if (rst_n && rec_valid) pulses++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One complete bus cycle. give_dv selects whether the qualifier comes.
    task automatic bus_cycle(input logic [23:0] a, input logic [2:0] fc, input logic rw,
                             input logic [15:0] d, input bit give_dv, input string req);
        bit fetch, expect_rec;
        int p0;
        fetch      = rw && (fc == 3'b010 || fc == 3'b110);
        expect_rec = fetch && give_dv;
        @(negedge clk);
        p0 = pulses;
        bus_addr = a; bus_fc = fc; bus_rw = rw; bus_data = 16'hDEAD; bus_as_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_addr = ~a; bus_fc = 3'b000; bus_rw = ~rw;   // R4: lines move after the edge
        if (give_dv) begin
            bus_data = d; bus_dv_n = 1'b0;
            repeat (3) @(negedge clk);
            chk({req, " valid at third edge (R6)"}, 32'(rec_valid), 32'(expect_rec));
            if (expect_rec) begin
                chk({req, " address (R4)"}, 32'(rec_addr), 32'(a));
                chk({req, " data (R5)"}, 32'(rec_data), 32'(d));
            end
            @(negedge clk);
            chk({req, " pulse ends (R6)"}, 32'(rec_valid), 32'd0);
            bus_dv_n = 1'b1;
            repeat (2) @(negedge clk);
        end
        bus_as_n = 1'b1; bus_data = 16'hBEEF;
        repeat (4) @(negedge clk);
        if (fetch && !give_dv && exp_err < ERR_MAX) exp_err++;
        chk({req, " record count"}, 32'(pulses - p0), 32'(expect_rec));
        chk({req, " err_count"}, 32'(err_count), 32'(exp_err));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 32'(rec_valid), 32'd0);
        chk("R1 err in reset", 32'(err_count), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", 32'(rec_valid), 32'd0);
        chk("R1 err after reset", 32'(err_count), 32'd0);
    endtask

    task automatic t_fc_modes();
        bus_cycle(24'h001000, 3'b010, 1'b1, 16'h4E71, 1'b1, "R2 user prog");
        bus_cycle(24'h00F00E, 3'b110, 1'b1, 16'h46FC, 1'b1, "R2 supv prog");
        bus_cycle(24'h002000, 3'b001, 1'b1, 16'h1111, 1'b1, "R2 user data");
        bus_cycle(24'h003000, 3'b101, 1'b1, 16'h2222, 1'b1, "R2 supv data");
        bus_cycle(24'hFFFFFE, 3'b111, 1'b1, 16'h3333, 1'b1, "R2 int ack");
        bus_cycle(24'h004000, 3'b101, 1'b1, 16'h0000, 1'b0, "R2 data early close");
    endtask

    task automatic t_write();
        bus_cycle(24'h005000, 3'b010, 1'b0, 16'h5555, 1'b1, "R3 write user prog");
        bus_cycle(24'h005002, 3'b110, 1'b0, 16'h6666, 1'b0, "R3 write no dv");
    endtask

    task automatic t_stream();
        bus_cycle(24'h0A0000, 3'b110, 1'b1, 16'h303C, 1'b1, "R7 opcode");
        bus_cycle(24'h0A0002, 3'b110, 1'b1, 16'h1234, 1'b1, "R7 ext1");
        bus_cycle(24'h0A0004, 3'b110, 1'b1, 16'h5678, 1'b1, "R7 ext2");
    endtask

    task automatic t_abort();
        bus_cycle(24'h00B000, 3'b010, 1'b1, 16'h0000, 1'b0, "R8 early close");
        chk("R8 err one", 32'(err_count), 32'd1);
        bus_cycle(24'h00B002, 3'b010, 1'b1, 16'h7777, 1'b1, "R8 recovers");
    endtask

    task automatic t_saturate();
        for (int i = 0; i < ERR_MAX + 2; i++)
            bus_cycle(24'h00C000 + 24'(i*2), 3'b110, 1'b1, 16'h0, 1'b0, "R9 abort");
        chk("R9 saturated", 32'(err_count), 32'(ERR_MAX));
    endtask

    task automatic t_double_dv();
        int p0;
        @(negedge clk);
        p0 = pulses;
        bus_addr = 24'h00D000; bus_fc = 3'b010; bus_rw = 1'b1; bus_data = 16'hDEAD;
        bus_as_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_data = 16'hA1A1; bus_dv_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 first record", 32'(rec_valid), 32'd1);
        chk("R10 first data", 32'(rec_data), 32'hA1A1);
        bus_dv_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_data = 16'hB2B2; bus_dv_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10 second edge ignored", 32'(pulses - p0), 32'd1);
        chk("R10 data kept", 32'(rec_data), 32'hA1A1);
        bus_dv_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_as_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        t_reset();
        t_fc_modes();
        t_write();
        t_stream();
        t_abort();
        t_double_dv();
        t_saturate();
        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1..R10 actual=timeout expected=done");
            summary();
            $finish;
        end
    end

endmodule